// File: doc/BRIEF.md
# Priority Interrupt Controller with Masking

This block chooses which pending interrupt, if any, the processor takes next. It has two kinds of input. User sources each carry a programmable priority from 0 to 7. Trap sources sit at the fixed levels 8 and above. The block keeps a current processor level. A candidate is taken only when its level is strictly above that current level. On acceptance the old level is pushed onto an internal stack, the current level is raised to the winner's level, and a one-cycle acknowledge is raised with the vector index and the level. A return pulse pops the stack and puts the saved level back.

Software reaches every source through a small word-wide register port. Through it, software also sets a no-nesting control bit and loads a countdown. While the countdown is running, user levels 1 to 6 are held off and level 7 still gets through. No user-side setting ever holds off a trap. Pending and trap flags stay set until software clears them. A handler that returns without clearing its flag therefore gets the same request again at once.

Top module: `prio_intc`

## Requirements
- R1: After reset every user source reads 0x04: priority 4, enable 0, pending 0. The trap, control and countdown registers read 0. The current level is 0 and no acknowledge is raised.
- R2: User source k sits at register address k. Bits [2:0] hold the priority, bit 3 the enable and bit 4 the pending flag. A write replaces all three fields. A one-cycle pulse on srcIrq[k] sets pending at the next edge, and this setting wins over a write that clears in the same cycle. Writing bit 4 as 0 clears pending.
- R3: A user source is a candidate when it is pending, enabled, has a nonzero priority and that priority is strictly greater than cpuLevel. The acknowledge appears one clock after the source becomes a candidate and lasts one cycle. It carries irqVec = k and irqLevel = priority. At the same edge cpuLevel becomes that priority. A priority-0 source is never taken.
- R4: Among candidates the highest level wins. Among equal levels the lowest vector index wins.
- R5: Once a level-7 source has been taken (cpuLevel 7), no user source is taken.
- R6: A write to address NUM_SRC+2 loads the countdown, which then decreases by one per clock down to 0 and reads back at the same address. While it is nonzero, user priorities 1 to 6 are not taken and priority 7 is.
- R7: Bit 0 of address NUM_SRC+1 is the no-nesting control and reads back there. While it is set and the stack is not empty, no user source is taken.
- R8: Trap t has level 8+t and vector NUM_SRC+t. Its flag is set by trapIrq[t], reads as bit t of address NUM_SRC, and is cleared by writing 1 to that bit. A trap is taken whenever cpuLevel is below its level, whatever the countdown or no-nesting state.
- R9: A retIn pulse with a non-empty stack restores the level saved at the matching acceptance, and nothing is taken in that cycle. A pending flag that is still set gets its source taken again one clock later. A retIn pulse with an empty stack has no effect.
- R10: With STACK_DEPTH entries saved, no further source is taken until a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIrq | input | NUM_SRC | One-cycle event pulses from the user sources |
| trapIrq | input | NUM_TRAP | One-cycle event pulses from the trap sources |
| regWe | input | 1 | Register write strobe |
| regAddr | input | clog2(NUM_SRC+3) | Register address |
| regWdata | input | REG_W | Register write data |
| regRdata | output | REG_W | Register read data for regAddr (combinational) |
| retIn | input | 1 | Return-from-handler pulse |
| irqAck | output | 1 | One-cycle acceptance strobe |
| irqVec | output | clog2(NUM_SRC+NUM_TRAP) | Vector index of the accepted source |
| irqLevel | output | 4 | Level of the accepted source |
| cpuLevel | output | 4 | Current processor level |

## Verification
The bench builds the block with eight user sources, four traps, an eight-bit countdown and the stack cut to four entries. The shallow stack lets a run of five rising priorities reach the full-stack stall in a few cycles. Eight sources by eight priorities is small enough to sweep every source at every priority, and to run every ordered pair of sources through the tie and priority rule. The countdown, no-nesting and trap cases are driven in short scripted sequences, and the expected vector and level are worked out arithmetically.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVL_W  = 4;
  localparam int PRIO_W = 3;
  localparam logic [PRIO_W-1:0] PRIO_RESET = 3'd4;
  localparam logic [PRIO_W-1:0] PRIO_TOP   = 3'd7;
  localparam logic [LVL_W-1:0]  TRAP_BASE  = 4'd8;

  // control -> datapath gating strobes
  typedef struct packed {
    logic             holdUser;  // nesting off and a handler active
    logic             holdLow;   // countdown running
    logic [LVL_W-1:0] curLevel;  // current processor level
  } gate_t;
endpackage

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_TRAP = 4,
  parameter int ADDR_W   = 4,
  parameter int REG_W    = 8,
  parameter int DP_W     = 5,
  parameter int VEC_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcIrq,
  input  logic [NUM_TRAP-1:0] trapIrq,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DP_W-1:0]     wdata,
  output logic [REG_W-1:0]    rdData,
  input  gate_t               gate,
  output logic                winValid,
  output logic [VEC_W-1:0]    winVec,
  output logic [LVL_W-1:0]    winLevel
);
  localparam logic [ADDR_W-1:0] TRAP_ADDR = ADDR_W'(NUM_SRC);

  logic [PRIO_W-1:0] prio [NUM_SRC];
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_TRAP-1:0] trapFlag;

  // per-source register slices
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic              hit;
    logic [PRIO_W-1:0] prioQ;
    logic              enQ;
    logic              pendQ;
    assign hit = regWe && (regAddr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioQ <= PRIO_RESET;
        enQ   <= 1'b0;
        pendQ <= 1'b0;
      end else begin
        if (hit) begin
          prioQ <= wdata[2:0];
          enQ   <= wdata[3];
        end
        pendQ <= (hit ? wdata[4] : pendQ) | srcIrq[i];
      end
    end

    assign prio[i] = prioQ;
    assign en[i]   = enQ;
    assign pend[i] = pendQ;

    p_pend_set_r2: assert property (@(posedge clk) disable iff (!rstN)
      srcIrq[i] |=> pend[i]);
  end

  // trap flags: set by event, write-one-to-clear
  logic [NUM_TRAP-1:0] trapClr;
  assign trapClr = (regWe && regAddr == TRAP_ADDR) ? wdata[NUM_TRAP-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trapFlag <= '0;
    else       trapFlag <= (trapFlag & ~trapClr) | trapIrq;
  end

  // arbitration: strict compare keeps lowest index on ties
  always_comb begin
    winLevel = '0;
    winVec   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      logic [LVL_W-1:0] lvl;
      logic ok;
      lvl = LVL_W'(prio[i]);
      ok  = pend[i] && en[i] && (prio[i] != '0) && (lvl > gate.curLevel)
            && !gate.holdUser && !(gate.holdLow && prio[i] != PRIO_TOP);
      if (ok && lvl > winLevel) begin
        winLevel = lvl;
        winVec   = VEC_W'(i);
      end
    end
    for (int t = 0; t < NUM_TRAP; t++) begin
      logic [LVL_W-1:0] tl;
      tl = TRAP_BASE + LVL_W'(t);
      if (trapFlag[t] && tl > gate.curLevel && tl > winLevel) begin
        winLevel = tl;
        winVec   = VEC_W'(NUM_SRC + t);
      end
    end
    winValid = (winLevel != '0);
  end

  // register read
  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (regAddr == ADDR_W'(i)) rdData = REG_W'({pend[i], en[i], prio[i]});
    if (regAddr == TRAP_ADDR) rdData = REG_W'(trapFlag);
  end

  p_above_cpl_r3: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> winLevel > gate.curLevel);
  p_low_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (gate.holdLow && winValid) |-> winLevel >= LVL_W'(PRIO_TOP));
  p_nest_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (gate.holdUser && winValid) |-> winLevel >= TRAP_BASE);
  p_trap_unmasked_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((|trapFlag) && gate.curLevel < TRAP_BASE) |-> (winValid && winLevel >= TRAP_BASE));
endmodule

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STACK_DEPTH = 8,
  parameter int ADDR_W      = 4,
  parameter int REG_W       = 8,
  parameter int DIS_W       = 8,
  parameter int VEC_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DIS_W-1:0] wdata,
  output logic [REG_W-1:0] rdData,
  input  logic             retIn,
  input  logic             winValid,
  input  logic [VEC_W-1:0] winVec,
  input  logic [LVL_W-1:0] winLevel,
  output gate_t            gate,
  output logic             irqAck,
  output logic [VEC_W-1:0] irqVec,
  output logic [LVL_W-1:0] irqLevel,
  output logic [LVL_W-1:0] cpuLevel
);
  localparam int DEPTH_W = $clog2(STACK_DEPTH + 1);
  localparam int PTR_W   = $clog2(STACK_DEPTH);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_SRC + 1);
  localparam logic [ADDR_W-1:0] DIS_ADDR  = ADDR_W'(NUM_SRC + 2);
  localparam logic [DEPTH_W-1:0] FULL     = DEPTH_W'(STACK_DEPTH);

  logic [LVL_W-1:0]   cpl;
  logic [LVL_W-1:0]   saved [STACK_DEPTH];
  logic [DEPTH_W-1:0] depth;
  logic [DIS_W-1:0]   disCnt;
  logic               nestOff;
  logic               accept;
  logic               pop;
  logic [PTR_W-1:0]   pushIdx;
  logic [PTR_W-1:0]   topIdx;

  assign accept  = winValid && !retIn && (depth < FULL);
  assign pop     = retIn && (depth != '0);
  assign pushIdx = PTR_W'(depth);
  assign topIdx  = PTR_W'(depth - DEPTH_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpl      <= '0;
      depth    <= '0;
      irqAck   <= 1'b0;
      irqVec   <= '0;
      irqLevel <= '0;
      for (int s = 0; s < STACK_DEPTH; s++) saved[s] <= '0;
    end else begin
      irqAck <= accept;
      if (accept) begin
        irqVec         <= winVec;
        irqLevel       <= winLevel;
        saved[pushIdx] <= cpl;
        cpl            <= winLevel;
        depth          <= depth + DEPTH_W'(1);
      end else if (pop) begin
        cpl   <= saved[topIdx];
        depth <= depth - DEPTH_W'(1);
      end
    end
  end

  // countdown and nesting control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disCnt  <= '0;
      nestOff <= 1'b0;
    end else begin
      if (regWe && regAddr == DIS_ADDR) disCnt <= wdata;
      else if (disCnt != '0)            disCnt <= disCnt - DIS_W'(1);
      if (regWe && regAddr == CTRL_ADDR) nestOff <= wdata[0];
    end
  end

  always_comb begin
    gate.curLevel = cpl;
    gate.holdLow  = (disCnt != '0);
    gate.holdUser = nestOff && (depth != '0);
  end

  always_comb begin
    rdData = '0;
    if (regAddr == CTRL_ADDR) rdData = REG_W'(nestOff);
    if (regAddr == DIS_ADDR)  rdData = REG_W'(disCnt);
  end

  assign cpuLevel = cpl;

  p_ack_raise_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> (cpl == irqLevel && irqLevel > $past(cpl)));
  p_pop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (retIn && depth != '0) |=> (!irqAck && depth == $past(depth) - DEPTH_W'(1)));
  p_ret_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    (retIn && depth == '0) |=> (cpl == $past(cpl) && depth == '0));
  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    depth <= FULL);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int NUM_TRAP    = 4,
  parameter int STACK_DEPTH = 8,
  parameter int REG_W       = 8,
  parameter int DIS_W       = 8,
  localparam int ADDR_W     = $clog2(NUM_SRC + 3),
  localparam int VEC_W      = $clog2(NUM_SRC + NUM_TRAP)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcIrq,
  input  logic [NUM_TRAP-1:0] trapIrq,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWdata,
  output logic [REG_W-1:0]    regRdata,
  input  logic                retIn,
  output logic                irqAck,
  output logic [VEC_W-1:0]    irqVec,
  output logic [3:0]          irqLevel,
  output logic [3:0]          cpuLevel
);
  localparam int DP_W = (NUM_TRAP > 5) ? NUM_TRAP : 5;

  gate_t            gate;
  logic             winValid;
  logic [VEC_W-1:0] winVec;
  logic [LVL_W-1:0] winLevel;
  logic [REG_W-1:0] dpRd;
  logic [REG_W-1:0] ctlRd;

  intc_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP), .ADDR_W(ADDR_W),
    .REG_W(REG_W), .DP_W(DP_W), .VEC_W(VEC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .trapIrq(trapIrq),
    .regWe(regWe), .regAddr(regAddr), .wdata(regWdata[DP_W-1:0]),
    .rdData(dpRd), .gate(gate), .winValid(winValid),
    .winVec(winVec), .winLevel(winLevel)
  );

  intc_control #(
    .NUM_SRC(NUM_SRC), .STACK_DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W),
    .REG_W(REG_W), .DIS_W(DIS_W), .VEC_W(VEC_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .wdata(regWdata[DIS_W-1:0]), .rdData(ctlRd), .retIn(retIn),
    .winValid(winValid), .winVec(winVec), .winLevel(winLevel),
    .gate(gate), .irqAck(irqAck), .irqVec(irqVec),
    .irqLevel(irqLevel), .cpuLevel(cpuLevel)
  );

  assign regRdata = (regAddr <= ADDR_W'(NUM_SRC)) ? dpRd : ctlRd;
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NT = 4;
  localparam int SD = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcIrq = '0;
  logic [NT-1:0] trapIrq = '0;
  logic          regWe = 1'b0;
  logic [3:0]    regAddr = '0;
  logic [7:0]    regWdata = '0;
  logic [7:0]    regRdata;
  logic          retIn = 1'b0;
  logic          irqAck;
  logic [3:0]    irqVec;
  logic [3:0]    irqLevel;
  logic [3:0]    cpuLevel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc #(.NUM_SRC(NS), .NUM_TRAP(NT), .STACK_DEPTH(SD), .REG_W(8), .DIS_W(8)) uut (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .trapIrq(trapIrq), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .retIn(retIn),
    .irqAck(irqAck), .irqVec(irqVec), .irqLevel(irqLevel), .cpuLevel(cpuLevel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    regWe = 1'b1; regAddr = 4'(a); regWdata = 8'(d);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    regAddr = 4'(a);
    #1;
    d = int'(regRdata);
  endtask

  task automatic pulseSrc(input int m);
    srcIrq = NS'(m);
    @(negedge clk);
    srcIrq = '0;
    @(negedge clk);
  endtask

  task automatic pulseTrap(input int m);
    trapIrq = NT'(m);
    @(negedge clk);
    trapIrq = '0;
    @(negedge clk);
  endtask

  task automatic ret();
    retIn = 1'b1;
    @(negedge clk);
    retIn = 1'b0;
  endtask

  task automatic expAck(input string tag, input int vec, input int lvl);
    chk({tag, " ack"}, int'(irqAck), 1);
    chk({tag, " vec"}, int'(irqVec), vec);
    chk({tag, " level"}, int'(irqLevel), lvl);
    chk({tag, " cpuLevel"}, int'(cpuLevel), lvl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < NS; i++) begin rd(i, v); chk("R1 source reset", v, 4); end
    rd(NS, v);   chk("R1 trap reset", v, 0);
    rd(NS+1, v); chk("R1 ctrl reset", v, 0);
    rd(NS+2, v); chk("R1 countdown reset", v, 0);
    chk("R1 cpuLevel", int'(cpuLevel), 0);
    chk("R1 no ack", int'(irqAck), 0);

    // R2 field layout and pending set/clear
    wr(3, 'h15); rd(3, v); chk("R2 write fields", v, 'h15);
    wr(3, 'h05); rd(3, v); chk("R2 sw clear pending", v, 'h05);
    pulseSrc(1 << 3); rd(3, v); chk("R2 hw set pending", v, 'h15);
    chk("R2 disabled not taken", int'(irqAck), 0);
    wr(3, 'h04); rd(3, v); chk("R2 restore", v, 4);

    // R3 sweep every source at every priority
    for (int i = 0; i < NS; i++) begin
      for (int p = 0; p < 8; p++) begin
        wr(i, 8 | p);
        pulseSrc(1 << i);
        if (p != 0) begin
          expAck("R3 sweep", i, p);
          @(negedge clk);
          chk("R3 ack one cycle", int'(irqAck), 0);
          wr(i, 4);
          ret();
          chk("R9 level restored", int'(cpuLevel), 0);
        end else begin
          chk("R3 prio zero never taken", int'(irqAck), 0);
          chk("R3 prio zero level", int'(cpuLevel), 0);
          wr(i, 4);
        end
      end
    end

    // R4 all ordered pairs
    for (int a = 0; a < NS; a++) begin
      for (int b = 0; b < NS; b++) begin
        if (a != b) begin
          int pa, pb, ev, el;
          pa = ((a + b) % 7) + 1;
          pb = ((a * 3 + b) % 7) + 1;
          if (pa > pb)      begin ev = a; el = pa; end
          else if (pb > pa) begin ev = b; el = pb; end
          else              begin ev = (a < b) ? a : b; el = pa; end
          wr(a, 8 | pa);
          wr(b, 8 | pb);
          pulseSrc((1 << a) | (1 << b));
          expAck("R4 pair", ev, el);
          wr(a, 4);
          wr(b, 4);
          ret();
          chk("R4 restored", int'(cpuLevel), 0);
        end
      end
    end

    // R5 level 7 blocks all users; R8 trap still taken
    wr(0, 'h0F);
    pulseSrc(1);
    expAck("R5 level7 taken", 0, 7);
    wr(1, 'h0F);
    wr(2, 'h0E);
    pulseSrc('b110);
    chk("R5 blocked at 7", int'(irqAck), 0);
    @(negedge clk);
    chk("R5 still blocked", int'(irqAck), 0);
    chk("R5 level held", int'(cpuLevel), 7);
    pulseTrap(1);
    expAck("R8 trap over level7", NS, 8);
    rd(NS, v); chk("R8 trap flag read", v, 1);
    wr(NS, 1); rd(NS, v); chk("R8 trap w1c", v, 0);
    ret();
    chk("R9 back to 7", int'(cpuLevel), 7);
    wr(0, 4); wr(1, 4); wr(2, 4);
    ret();
    chk("R9 back to 0", int'(cpuLevel), 0);
    @(negedge clk);
    chk("R5 cleared none taken", int'(irqAck), 0);

    // R6 countdown
    wr(NS+2, 5);
    rd(NS+2, v); chk("R6 load", v, 5);
    @(negedge clk);
    rd(NS+2, v); chk("R6 decrement", v, 4);
    repeat (4) @(negedge clk);
    rd(NS+2, v); chk("R6 reaches zero", v, 0);
    @(negedge clk);
    rd(NS+2, v); chk("R6 stays zero", v, 0);
    wr(0, 'h0E);
    wr(1, 'h0F);
    wr(NS+2, 30);
    pulseSrc(1);
    chk("R6 level6 held", int'(irqAck), 0);
    chk("R6 level unchanged", int'(cpuLevel), 0);
    pulseSrc(2);
    expAck("R6 level7 passes", 1, 7);
    pulseTrap(4);
    expAck("R8 trap during countdown", NS + 2, 10);
    wr(NS, 4);
    ret();
    chk("R9 trap return", int'(cpuLevel), 7);
    wr(1, 'h0F);
    repeat (32) @(negedge clk);
    rd(NS+2, v); chk("R6 expired", v, 0);
    chk("R5 no ack at 7", int'(irqAck), 0);
    ret();
    chk("R9 return to 0", int'(cpuLevel), 0);
    @(negedge clk);
    expAck("R6 held source after expiry", 0, 6);
    wr(0, 4);
    ret();
    chk("R6 cleanup", int'(cpuLevel), 0);

    // R7 no-nesting
    wr(NS+1, 1); rd(NS+1, v); chk("R7 ctrl readback", v, 1);
    wr(0, 'h0A);
    wr(1, 'h0D);
    pulseSrc(1);
    expAck("R7 first taken", 0, 2);
    pulseSrc(2);
    chk("R7 nested user held", int'(irqAck), 0);
    chk("R7 level held", int'(cpuLevel), 2);
    pulseTrap(2);
    expAck("R8 trap under no-nesting", NS + 1, 9);
    wr(NS, 2);
    ret();
    chk("R9 back to 2", int'(cpuLevel), 2);
    @(negedge clk);
    chk("R7 still held with active handler", int'(irqAck), 0);
    wr(0, 'h0A);
    ret();
    chk("R9 back to 0 nest", int'(cpuLevel), 0);
    @(negedge clk);
    expAck("R7 taken after handler end", 1, 5);
    wr(1, 'h0D);
    ret();
    wr(NS+1, 0); rd(NS+1, v); chk("R7 ctrl cleared", v, 0);
    wr(0, 4); wr(1, 4);

    // R9 retake and empty return
    wr(0, 'h0B);
    pulseSrc(1);
    expAck("R9 first", 0, 3);
    ret();
    chk("R9 pop level", int'(cpuLevel), 0);
    @(negedge clk);
    expAck("R9 retaken", 0, 3);
    wr(0, 4);
    ret();
    chk("R9 clean", int'(cpuLevel), 0);
    ret();
    chk("R9 empty return ignored", int'(cpuLevel), 0);
    chk("R9 empty return no ack", int'(irqAck), 0);

    // R10 full stack
    for (int i = 0; i < SD + 1; i++) wr(i, 8 | (i + 1));
    for (int i = 0; i < SD + 1; i++) begin
      pulseSrc(1 << i);
      if (i < SD) expAck("R10 fill", i, i + 1);
      else begin
        chk("R10 full blocks", int'(irqAck), 0);
        chk("R10 full level", int'(cpuLevel), SD);
      end
    end
    for (int i = 0; i < SD + 1; i++) wr(i, 4);
    for (int k = SD - 1; k >= 0; k--) begin
      ret();
      chk("R9 unwind order", int'(cpuLevel), k);
    end
    @(negedge clk);
    chk("R10 nothing left", int'(irqAck), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule